// File: doc/BRIEF.md
# Isolated Fault Pulse Encoder

This block sits on the driven side of an isolated gate driver. It reports fault conditions back across the barrier by pulsing two transformer switch enables. Supply faults are tied to the PWM edges. The supply state is captured once, when the leading-edge strobe arrives, and it decides which edge-tied pulses that cycle produces. An undervoltage cycle pulses line A at the leading edge only. An overvoltage cycle pulses line A at the leading edge and line B at the trailing edge. The far side therefore reads overvoltage only from the pair.

An overcurrent trip may arrive at any point in the ON period. It fires line B through its own one-shot. Every pulse is a fixed number of clock cycles wide. A line that is already pulsing, or that is in its one-cycle recovery slot, ignores new start requests. Consecutive pulses on one line are therefore always separated by a low cycle.

Top module: `fault_pulse_encoder`

## Requirements
- R1: A leading-edge strobe with `uvFault`=1 and `ovFault`=0 starts one pulse on `faultLineA` and no edge-tied pulse on `faultLineB` at the following trailing edge.
- R2: A leading-edge strobe with `ovFault`=1 starts a pulse on `faultLineA`, and the next trailing-edge strobe starts a pulse on `faultLineB`.
- R3: When `uvFault` and `ovFault` are both 1 at the leading edge, the cycle is encoded as overvoltage (pulses on both lines).
- R4: The supply fault levels are sampled only on the leading-edge strobe. Changes between the leading and trailing strobes do not change that cycle's pulses.
- R5: An `ocTrip` strobe starts a pulse on `faultLineB`, independent of the supply state.
- R6: Each pulse is high for exactly `PULSE_CYCLES` clock cycles. The output goes high in the cycle after the edge that sampled the start request.
- R7: A start request that arrives while a line is high, or in the single low cycle right after its pulse ends, is ignored without lengthening the pulse. A request one cycle later is accepted, so the gap between pulses can be exactly one cycle.
- R8: With no fault inputs set, both outputs stay low, including across leading and trailing strobes.
- R9: Asserting `rstN` low forces both outputs low at once, ends any pulse in progress and discards the captured supply state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| leadStrobe | input | 1 | One-cycle strobe at the PWM ON edge |
| trailStrobe | input | 1 | One-cycle strobe at the PWM OFF edge |
| uvFault | input | 1 | Supply undervoltage level, sampled on `leadStrobe` |
| ovFault | input | 1 | Supply overvoltage level, sampled on `leadStrobe` |
| ocTrip | input | 1 | One-cycle overcurrent trip strobe |
| faultLineA | output | 1 | Switch enable for transformer line A |
| faultLineB | output | 1 | Switch enable for transformer line B |

## Verification
The hardest situation to reach is a start request that lands on the exact boundary of a running pulse. A request on the last high cycle must be dropped. A request on the one recovery cycle after it must be accepted. The bench sends two overcurrent strobes spaced exactly `PULSE_CYCLES` edges apart and then `PULSE_CYCLES`+1 edges apart. It checks one pulse in the first case and two pulses with a single low sample between them in the second. Supply levels that change between the leading and trailing strobes are driven on purpose, so that sampling at the wrong moment would show up.

// File: rtl/fpe_pkg.sv
`timescale 1ns/1ps
package fpe_pkg;
  // Start requests sent from the control to the pulse datapath
  typedef struct packed {
    logic fireA;
    logic fireB;
  } fireReq_t;

  // Supply condition captured for the current PWM cycle
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_UV   = 2'd1,
    KIND_OV   = 2'd2
  } cycleKind_t;
endpackage

// File: rtl/fpe_ctrl.sv
`timescale 1ns/1ps
module fpe_ctrl
  import fpe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     leadStrobe,
  input  logic     trailStrobe,
  input  logic     uvFault,
  input  logic     ovFault,
  input  logic     ocTrip,
  output fireReq_t req
);
  cycleKind_t cycleKind;
  cycleKind_t leadKind;

  // Overvoltage outranks undervoltage when both are seen together
  always_comb begin
    if (ovFault)      leadKind = KIND_OV;
    else if (uvFault) leadKind = KIND_UV;
    else              leadKind = KIND_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cycleKind <= KIND_NONE;
    else if (leadStrobe)  cycleKind <= leadKind;
    else if (trailStrobe) cycleKind <= KIND_NONE;
  end

  always_comb begin
    req.fireA = leadStrobe && (leadKind != KIND_NONE);
    req.fireB = (trailStrobe && (cycleKind == KIND_OV)) || ocTrip;
  end

  // R4: captured state changes only on a strobe
  a_r4_kind_held: assert property (@(posedge clk) disable iff (!rstN)
    !leadStrobe && !trailStrobe |=> $stable(cycleKind));
  // R3: overvoltage wins at the leading edge
  a_r3_ov_wins: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe && ovFault |=> cycleKind == KIND_OV);
  // R1: undervoltage alone never arms the trailing pulse
  a_r1_uv_kind: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe && uvFault && !ovFault |=> cycleKind == KIND_UV);
endmodule

// File: rtl/fpe_pulse_dp.sv
`timescale 1ns/1ps
module fpe_pulse_dp
  import fpe_pkg::*;
#(
  parameter int PULSE_CYCLES = 25,
  parameter int NUM_LINES    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fireReq_t             req,
  output logic [NUM_LINES-1:0] lineOut
);
  localparam int CW = $clog2(PULSE_CYCLES + 2);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES + 1);

  logic [NUM_LINES-1:0] fireVec;
  assign fireVec = NUM_LINES'({req.fireB, req.fireA});

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CW-1:0] cnt;
    logic [CW-1:0] runLen;

    // cnt above 1: pulse high; cnt == 1: recovery slot; restart allowed from 1
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                cnt <= '0;
      else if (fireVec[g] && cnt <= CW'(1))     cnt <= LOAD_VAL;
      else if (cnt != '0)                       cnt <= cnt - CW'(1);
    end

    assign lineOut[g] = (cnt >= CW'(2));

    // Length of the current high run, used by the width check
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           runLen <= '0;
      else if (lineOut[g]) runLen <= runLen + CW'(1);
      else                 runLen <= '0;
    end

    // R6 / R7: every completed pulse has exactly the set width, never extended
    a_r6_width: assert property (@(posedge clk) disable iff (!rstN)
      $fell(lineOut[g]) |-> runLen == CW'(PULSE_CYCLES));
    a_r7_no_extend: assert property (@(posedge clk) disable iff (!rstN)
      lineOut[g] |-> runLen < CW'(PULSE_CYCLES));
  end
endmodule

// File: rtl/fault_pulse_encoder.sv
`timescale 1ns/1ps
module fault_pulse_encoder
  import fpe_pkg::*;
#(
  parameter int PULSE_CYCLES = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic leadStrobe,
  input  logic trailStrobe,
  input  logic uvFault,
  input  logic ovFault,
  input  logic ocTrip,
  output logic faultLineA,
  output logic faultLineB
);
  fireReq_t   req;
  logic [1:0] lines;

  fpe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe),
    .uvFault(uvFault), .ovFault(ovFault), .ocTrip(ocTrip), .req(req)
  );

  fpe_pulse_dp #(.PULSE_CYCLES(PULSE_CYCLES), .NUM_LINES(2)) u_dp (
    .clk(clk), .rstN(rstN), .req(req), .lineOut(lines)
  );

  assign faultLineA = lines[0];
  assign faultLineB = lines[1];

  // R1 / R2: line A rises only after a leading edge with a supply fault
  a_r1_a_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLineA) |-> $past(leadStrobe) && $past(uvFault || ovFault));
  // R5: line B rises only after a trip or a trailing edge
  a_r5_b_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLineB) |-> $past(ocTrip) || $past(trailStrobe));
  // R8: with no strobes at all, no line can start
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !leadStrobe && !trailStrobe && !ocTrip |=> !$rose(faultLineA) && !$rose(faultLineB));
endmodule

// File: tb/fault_pulse_encoder_bench.sv
`timescale 1ns/1ps
module fault_pulse_encoder_bench;
  localparam int PW = 6;
  localparam int NV = 10;
  // bits: [7] uv, [6] ov, [5] flip ov after lead, [4] trip mid-cycle,
  //       [3:2] expected line A pulses, [1:0] expected line B pulses
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_00_00,  // R8 no fault
    8'b1000_01_00,  // R1 undervoltage only
    8'b0100_01_01,  // R2 overvoltage
    8'b1100_01_01,  // R3 both set, overvoltage wins
    8'b0001_00_01,  // R5 trip only
    8'b1001_01_01,  // R5 undervoltage plus trip
    8'b0110_01_01,  // R4 overvoltage dropped after lead
    8'b0010_00_00,  // R4 overvoltage raised after lead
    8'b1010_01_00,  // R4 undervoltage, overvoltage raised after lead
    8'b0101_01_10   // R5 overvoltage plus trip: two on B
  };

  logic clk = 0, rstN = 0;
  logic leadStrobe = 0, trailStrobe = 0, uvFault = 0, ovFault = 0, ocTrip = 0;
  logic faultLineA, faultLineB;
  int total = 0, failed = 0, riseA = 0, riseB = 0, runA = 0, runB = 0;
  logic prevA = 0, prevB = 0, finished = 0;

  always #4 clk = ~clk;

  fault_pulse_encoder #(.PULSE_CYCLES(PW)) u_fault_pulse_encoder (
    .clk(clk), .rstN(rstN), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe),
    .uvFault(uvFault), .ovFault(ovFault), .ocTrip(ocTrip),
    .faultLineA(faultLineA), .faultLineB(faultLineB)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse monitor: counts rises and checks each pulse width (R6)
  always @(negedge clk) begin
    if (!rstN) begin
      runA = 0; runB = 0;
    end else begin
      if (faultLineA && !prevA) riseA++;
      if (faultLineB && !prevB) riseB++;
      if (!faultLineA && prevA) check(runA == PW, "R6 width A", runA, PW);
      if (!faultLineB && prevB) check(runB == PW, "R6 width B", runB, PW);
      runA = faultLineA ? runA + 1 : 0;
      runB = faultLineB ? runB + 1 : 0;
    end
    prevA = faultLineA;
    prevB = faultLineB;
  end

  function automatic string vecTag(input int i);
    case (i)
      0: return "R8";
      1, 8: return "R1";
      2: return "R2";
      3: return "R3";
      6, 7: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(faultLineA == 0 && faultLineB == 0, "R9 reset state",
          {faultLineA, faultLineB}, 0);
    rstN = 1;
    repeat (4) @(negedge clk);
    check(faultLineA == 0 && faultLineB == 0, "R8 idle after reset",
          {faultLineA, faultLineB}, 0);

    for (int i = 0; i < NV; i++) begin
      riseA = 0; riseB = 0;
      uvFault = VEC[i][7]; ovFault = VEC[i][6]; leadStrobe = 1;
      @(negedge clk);
      leadStrobe = 0;
      if (VEC[i][5]) ovFault = ~ovFault;
      check(faultLineA == (VEC[i][3:2] != 0), {vecTag(i), " A after lead"},
            faultLineA, int'(VEC[i][3:2] != 0));
      repeat (9) @(negedge clk);
      ocTrip = VEC[i][4];
      @(negedge clk);
      ocTrip = 0;
      repeat (9) @(negedge clk);
      trailStrobe = 1;
      @(negedge clk);
      trailStrobe = 0; uvFault = 0; ovFault = 0;
      repeat (15) @(negedge clk);
      check(riseA == int'(VEC[i][3:2]), {vecTag(i), " pulses on A"}, riseA, int'(VEC[i][3:2]));
      check(riseB == int'(VEC[i][1:0]), {vecTag(i), " pulses on B"}, riseB, int'(VEC[i][1:0]));
    end

    // R7: trip arriving on the last high cycle is dropped
    riseB = 0;
    ocTrip = 1; @(negedge clk); ocTrip = 0;
    repeat (PW - 1) @(negedge clk);
    ocTrip = 1; @(negedge clk); ocTrip = 0;
    repeat (15) @(negedge clk);
    check(riseB == 1, "R7 overlap dropped", riseB, 1);

    // R7: trip in the recovery slot is taken, leaving one low cycle
    riseB = 0;
    ocTrip = 1; @(negedge clk); ocTrip = 0;
    repeat (PW) @(negedge clk);
    check(faultLineB == 0, "R7 one low cycle", faultLineB, 0);
    ocTrip = 1; @(negedge clk); ocTrip = 0;
    check(faultLineB == 1, "R7 restart after gap", faultLineB, 1);
    repeat (15) @(negedge clk);
    check(riseB == 2, "R7 two pulses", riseB, 2);

    // R9: reset cuts a pulse and forgets the captured overvoltage
    riseB = 0;
    ovFault = 1; leadStrobe = 1; @(negedge clk); leadStrobe = 0; ovFault = 0;
    @(negedge clk);
    check(faultLineA == 1, "R9 pulse running", faultLineA, 1);
    #1 rstN = 0;
    #1 check(faultLineA == 0, "R9 reset cuts pulse", faultLineA, 0);
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    trailStrobe = 1; @(negedge clk); trailStrobe = 0;
    repeat (10) @(negedge clk);
    check(riseB == 0, "R9 captured state cleared", riseB, 0);
    check(faultLineA == 0 && faultLineB == 0, "R8 quiet at end",
          {faultLineA, faultLineB}, 0);
    summary();
  end
endmodule